// File: doc/BRIEF.md
# Buffered Input Capture Channel

This block is one input-capture channel of a timer. When a qualified edge arrives from the pin, the channel stores the present value of a free-running timer count in a capture register. A second, holding register can keep an older capture so that software does not lose a time stamp before it reads one. Pin edge detection and filtering, the timer counter and the modulus down-counter are outside the block. They arrive as a one-cycle edge strobe, a count bus and a latch-event strobe.

There are three operating styles. With the holding register disabled, every edge simply reloads the capture register. In queue mode the two registers form a two-deep first-in-first-out pair: the older stamp moves to the holding register when a newer one arrives. A no-overwrite control keeps a full pair from losing data. In latch mode an edge refreshes only the capture register. The capture register is copied into the holding register on a latch event, which is either the external strobe or a software force-latch write strobe. An interrupt flag is set on captures, or, when selected in queue mode, only on holding-register loads. Software clears the flag by writing one to it.

Top module: `icap_buffered_channel`

## Requirements
- R1: During and after synchronous reset, cap_val and hold_val are 0, flag is 0, and both registers are empty.
- R2: With buf_en=0, an edge_vld strobe loads tmr_cnt into cap_val one cycle later. hold_val never changes in this mode.
- R3: With buf_en=1 and latch_sel=0 (queue), an edge_vld while the capture register is full moves the old cap_val to hold_val and loads tmr_cnt into cap_val, both in the same cycle.
- R4: In queue mode, an edge_vld while the capture register is empty loads only cap_val. hold_val keeps its value.
- R5: With buf_en=1 and latch_sel=1 (latch), edge_vld loads tmr_cnt into cap_val and leaves hold_val unchanged.
- R6: In latch mode, latch_evt or force_latch_wr copies cap_val into hold_val. When an edge arrives in the same cycle, hold_val takes the old cap_val and cap_val takes tmr_cnt.
- R7: With flag_mode=0, or with flag_mode=1 outside queue mode, every accepted edge sets flag.
- R8: With flag_mode=1 in queue mode, flag is set only in the cycle hold_val is loaded, so the first edge into an empty pair sets no flag.
- R9: With no_ovw=1 in queue mode, an edge arriving while both registers are full is dropped: cap_val, hold_val and flag stay unchanged.
- R10: A cap_rd or hold_rd pulse marks that register empty. A load in the same cycle leaves it full. Loading marks a register full.
- R11: A flag_clr pulse clears flag. A set cause in the same cycle wins and flag stays 1.
- R12: latch_evt and force_latch_wr have no effect on hold_val unless buf_en=1 and latch_sel=1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| tmr_cnt | input | CNT_W | Free-running timer count |
| edge_vld | input | 1 | One-cycle qualified pin edge strobe |
| buf_en | input | 1 | Enables the holding register |
| latch_sel | input | 1 | 1 = latch mode, 0 = queue mode (when buf_en=1) |
| flag_mode | input | 1 | 1 = in queue mode, flag only on holding load |
| no_ovw | input | 1 | Queue mode: drop edges while both registers are full |
| latch_evt | input | 1 | Latch event strobe from the modulus counter |
| force_latch_wr | input | 1 | Software force-latch write strobe |
| cap_rd | input | 1 | CPU read of the capture register |
| hold_rd | input | 1 | CPU read of the holding register |
| flag_clr | input | 1 | Write-one-to-clear strobe for the flag |
| cap_val | output | CNT_W | Capture register value |
| hold_val | output | CNT_W | Holding register value |
| flag | output | 1 | Channel interrupt flag |

## Verification
The case that is hardest to reach from the ports is a no-overwrite drop. It needs queue mode, both registers full and unread, and then one more edge. Random reads and mode changes seldom leave the pair in that state. A directed sequence therefore fills the pair with two edges, clears the flag, sends a third edge and checks that nothing moved. It then reads both registers and shows that the next edge fills only the capture register. Random traffic is weighted toward rare reads and holds each mode setting for many cycles, so that full pairs and same-cycle latch and edge collisions also occur under random stimulus.

// File: rtl/icap_pkg.sv
package icap_pkg;

    typedef enum logic [1:0] {
        MODE_DIRECT = 2'd0,
        MODE_QUEUE  = 2'd1,
        MODE_LATCH  = 2'd2
    } icap_mode_e;

    typedef struct packed {
        logic load_cap;
        logic move_hold;
        logic set_flag;
    } icap_act_t;

    function automatic icap_mode_e decode_mode(input logic buf_en, input logic latch_sel);
        if (!buf_en)
            return MODE_DIRECT;
        else if (latch_sel)
            return MODE_LATCH;
        else
            return MODE_QUEUE;
    endfunction

endpackage

// File: rtl/icap_ctrl.sv
module icap_ctrl
    import icap_pkg::*;
(
    input  logic       buf_en,
    input  logic       latch_sel,
    input  logic       flag_mode,
    input  logic       no_ovw,
    input  logic       edge_vld,
    input  logic       latch_evt,
    input  logic       force_latch_wr,
    input  logic       cap_full,
    input  logic       hold_full,
    output icap_mode_e mode,
    output icap_act_t  act
);
    logic blocked;
    logic accept;
    logic move;

    always_comb begin
        mode    = decode_mode(buf_en, latch_sel);
        blocked = (mode == MODE_QUEUE) && no_ovw && cap_full && hold_full;
        accept  = edge_vld && !blocked;
        case (mode)
            MODE_QUEUE: move = accept && cap_full;
            MODE_LATCH: move = latch_evt || force_latch_wr;
            default:    move = 1'b0;
        endcase
        act.load_cap  = accept;
        act.move_hold = move;
        act.set_flag  = (flag_mode && mode == MODE_QUEUE) ? move : accept;
    end
endmodule

// File: rtl/icap_regs.sv
module icap_regs
    import icap_pkg::*;
#(
    parameter int CNT_W = 16
) (
    input  logic             clk,
    input  logic             rst,
    input  logic [CNT_W-1:0] tmr_cnt,
    input  icap_mode_e       mode,
    input  icap_act_t        act,
    input  logic             no_ovw,
    input  logic             edge_vld,
    input  logic             latch_trig,
    input  logic             cap_rd,
    input  logic             hold_rd,
    output logic [CNT_W-1:0] cap_q,
    output logic [CNT_W-1:0] hold_q,
    output logic             cap_full_q,
    output logic             hold_full_q
);
    always_ff @(posedge clk) begin
        if (rst) begin
            cap_q       <= '0;
            hold_q      <= '0;
            cap_full_q  <= 1'b0;
            hold_full_q <= 1'b0;
        end else begin
            if (act.load_cap) begin
                cap_q      <= tmr_cnt;
                cap_full_q <= 1'b1;
            end else if (cap_rd) begin
                cap_full_q <= 1'b0;
            end
            if (act.move_hold) begin
                hold_q      <= cap_q;
                hold_full_q <= 1'b1;
            end else if (hold_rd) begin
                hold_full_q <= 1'b0;
            end
        end
    end

    p_direct_hold_r2: assert property (@(posedge clk) disable iff (rst)
        (mode == MODE_DIRECT) |=> $stable(hold_q));

    p_queue_shift_r3: assert property (@(posedge clk) disable iff (rst)
        (mode == MODE_QUEUE && edge_vld && cap_full_q && !(no_ovw && hold_full_q))
        |=> (hold_q == $past(cap_q)) && (cap_q == $past(tmr_cnt)));

    p_latch_copy_r6: assert property (@(posedge clk) disable iff (rst)
        (mode == MODE_LATCH && latch_trig) |=> hold_q == $past(cap_q));

    p_noovw_drop_r9: assert property (@(posedge clk) disable iff (rst)
        (mode == MODE_QUEUE && no_ovw && cap_full_q && hold_full_q)
        |=> $stable(cap_q) && $stable(hold_q));

    p_no_latch_outside_r12: assert property (@(posedge clk) disable iff (rst)
        (mode != MODE_LATCH && !(mode == MODE_QUEUE && edge_vld)) |=> $stable(hold_q));
endmodule

// File: rtl/icap_flag.sv
module icap_flag (
    input  logic clk,
    input  logic rst,
    input  logic set_evt,
    input  logic flag_clr,
    output logic flag_q
);
    always_ff @(posedge clk) begin
        if (rst)
            flag_q <= 1'b0;
        else if (set_evt)
            flag_q <= 1'b1;
        else if (flag_clr)
            flag_q <= 1'b0;
    end

    p_set_wins_r11: assert property (@(posedge clk) disable iff (rst)
        set_evt |=> flag_q);

    p_clear_r11: assert property (@(posedge clk) disable iff (rst)
        (flag_clr && !set_evt) |=> !flag_q);

    p_hold_r7: assert property (@(posedge clk) disable iff (rst)
        (!flag_clr && !set_evt) |=> $stable(flag_q));
endmodule

// File: rtl/icap_buffered_channel.sv
module icap_buffered_channel
    import icap_pkg::*;
#(
    parameter int CNT_W = 16
) (
    input  logic             clk,
    input  logic             rst,
    input  logic [CNT_W-1:0] tmr_cnt,
    input  logic             edge_vld,
    input  logic             buf_en,
    input  logic             latch_sel,
    input  logic             flag_mode,
    input  logic             no_ovw,
    input  logic             latch_evt,
    input  logic             force_latch_wr,
    input  logic             cap_rd,
    input  logic             hold_rd,
    input  logic             flag_clr,
    output logic [CNT_W-1:0] cap_val,
    output logic [CNT_W-1:0] hold_val,
    output logic             flag
);
    icap_mode_e mode;
    icap_act_t  act;
    logic       cap_full;
    logic       hold_full;
    logic       latch_trig;

    assign latch_trig = latch_evt || force_latch_wr;

    icap_ctrl u_ctrl (
        .buf_en         (buf_en),
        .latch_sel      (latch_sel),
        .flag_mode      (flag_mode),
        .no_ovw         (no_ovw),
        .edge_vld       (edge_vld),
        .latch_evt      (latch_evt),
        .force_latch_wr (force_latch_wr),
        .cap_full       (cap_full),
        .hold_full      (hold_full),
        .mode           (mode),
        .act            (act)
    );

    icap_regs #(.CNT_W(CNT_W)) u_regs (
        .clk         (clk),
        .rst         (rst),
        .tmr_cnt     (tmr_cnt),
        .mode        (mode),
        .act         (act),
        .no_ovw      (no_ovw),
        .edge_vld    (edge_vld),
        .latch_trig  (latch_trig),
        .cap_rd      (cap_rd),
        .hold_rd     (hold_rd),
        .cap_q       (cap_val),
        .hold_q      (hold_val),
        .cap_full_q  (cap_full),
        .hold_full_q (hold_full)
    );

    icap_flag u_flag (
        .clk      (clk),
        .rst      (rst),
        .set_evt  (act.set_flag),
        .flag_clr (flag_clr),
        .flag_q   (flag)
    );

    p_reset_r1: assert property (@(posedge clk)
        rst |=> (cap_val == '0) && (hold_val == '0) && !flag && !cap_full && !hold_full);

    p_load_full_r10: assert property (@(posedge clk) disable iff (rst)
        (edge_vld && !(mode == MODE_QUEUE && no_ovw && cap_full && hold_full)) |=> cap_full);

    p_queue_flag_r8: assert property (@(posedge clk) disable iff (rst)
        (mode == MODE_QUEUE && flag_mode && edge_vld && !cap_full && !flag && !flag_clr)
        |=> !flag);
endmodule

// File: tb/test_icap_buffered_channel.sv
`timescale 1ns/1ps
module test_icap_buffered_channel;
    localparam int CNT_W = 16;

    logic             clk = 1'b0;
    logic             rst;
    logic [CNT_W-1:0] tmr_cnt;
    logic             edge_vld, buf_en, latch_sel, flag_mode, no_ovw;
    logic             latch_evt, force_latch_wr, cap_rd, hold_rd, flag_clr;
    logic [CNT_W-1:0] cap_val, hold_val;
    logic             flag;

    int errors = 0;
    int checks = 0;
    bit finished = 0;

    // bench reference state
    logic [CNT_W-1:0] m_cap, m_hold;
    logic             m_capf, m_holdf, m_flag;

    always #2 clk = ~clk;

    icap_buffered_channel #(.CNT_W(CNT_W)) i_icap_buffered_channel (
        .clk(clk), .rst(rst), .tmr_cnt(tmr_cnt), .edge_vld(edge_vld),
        .buf_en(buf_en), .latch_sel(latch_sel), .flag_mode(flag_mode),
        .no_ovw(no_ovw), .latch_evt(latch_evt), .force_latch_wr(force_latch_wr),
        .cap_rd(cap_rd), .hold_rd(hold_rd), .flag_clr(flag_clr),
        .cap_val(cap_val), .hold_val(hold_val), .flag(flag)
    );

    task automatic check(input string tag, input logic [CNT_W-1:0] act, input logic [CNT_W-1:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    function automatic string mode_tag();
        if (!buf_en) return "R2";
        if (latch_sel) return "R5";
        return "R3";
    endfunction

    task automatic model_update();
        bit qm, lm, drop, acc, mv, setf;
        qm   = buf_en && !latch_sel;
        lm   = buf_en && latch_sel;
        drop = qm && no_ovw && m_capf && m_holdf;
        acc  = edge_vld && !drop;
        mv   = (qm && acc && m_capf) || (lm && (latch_evt || force_latch_wr));
        setf = (flag_mode && qm) ? mv : acc;
        if (mv) begin m_hold = m_cap; m_holdf = 1'b1; end
        else if (hold_rd) m_holdf = 1'b0;
        if (acc) begin m_cap = tmr_cnt; m_capf = 1'b1; end
        else if (cap_rd) m_capf = 1'b0;
        if (setf) m_flag = 1'b1;
        else if (flag_clr) m_flag = 1'b0;
    endtask

    task automatic idle_inputs();
        edge_vld = 0; latch_evt = 0; force_latch_wr = 0;
        cap_rd = 0; hold_rd = 0; flag_clr = 0;
    endtask

    // one clock with given strobes, checked against the reference
    task automatic step(input bit e, input logic [CNT_W-1:0] tm, input bit lev, input bit flw,
                        input bit crd, input bit hrd, input bit fclr);
        string t;
        @(negedge clk);
        edge_vld = e; tmr_cnt = tm; latch_evt = lev; force_latch_wr = flw;
        cap_rd = crd; hold_rd = hrd; flag_clr = fclr;
        t = mode_tag();
        model_update();
        @(posedge clk); #1;
        check({t, " cap"}, cap_val, m_cap);
        check({t, " hold"}, hold_val, m_hold);
        check({t, " flag"}, {15'd0, flag}, {15'd0, m_flag});
        idle_inputs();
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst = 1; idle_inputs();
        @(posedge clk); @(posedge clk); #1;
        m_cap = '0; m_hold = '0; m_capf = 0; m_holdf = 0; m_flag = 0;
        @(negedge clk);
        rst = 0;
    endtask

    task automatic set_mode(input bit be, input bit ls, input bit fm, input bit nov);
        @(negedge clk);
        buf_en = be; latch_sel = ls; flag_mode = fm; no_ovw = nov;
    endtask

    initial begin
        #2_000_000;
        if (!finished) begin
            errors++; checks++;
            $display("FAIL watchdog expired actual=running expected=done");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

    initial begin
        void'($urandom(32'h5eed_1c0f));
        rst = 1; tmr_cnt = '0; buf_en = 0; latch_sel = 0; flag_mode = 0; no_ovw = 0;
        idle_inputs();
        do_reset();
        // R1: reset state
        check("R1 cap", cap_val, 16'h0);
        check("R1 hold", hold_val, 16'h0);
        check("R1 flag", {15'd0, flag}, 16'h0);

        // R2 direct mode, R7 flag, R12 latch strobes ignored
        set_mode(0, 0, 0, 0);
        step(1, 16'h1111, 0, 0, 0, 0, 0);
        check("R2 cap load", cap_val, 16'h1111);
        check("R7 flag on edge", {15'd0, flag}, 16'h1);
        step(0, 16'h0, 1, 1, 0, 0, 0);
        check("R12 hold unchanged", hold_val, 16'h0);
        step(0, 16'h0, 0, 0, 0, 0, 1);
        check("R11 clear", {15'd0, flag}, 16'h0);

        // queue mode, R4 then R3
        do_reset();
        set_mode(1, 0, 0, 0);
        step(1, 16'hA0A0, 0, 0, 0, 0, 0);
        check("R4 cap only", cap_val, 16'hA0A0);
        check("R4 hold kept", hold_val, 16'h0);
        step(1, 16'hB0B0, 0, 0, 0, 0, 0);
        check("R3 shift hold", hold_val, 16'hA0A0);
        check("R3 new cap", cap_val, 16'hB0B0);

        // R8 flag only on holding load
        do_reset();
        set_mode(1, 0, 1, 0);
        step(1, 16'h0101, 0, 0, 0, 0, 0);
        check("R8 no flag first", {15'd0, flag}, 16'h0);
        step(1, 16'h0202, 0, 0, 0, 0, 0);
        check("R8 flag on move", {15'd0, flag}, 16'h1);

        // R9 drop when both full; R10 read empties
        set_mode(1, 0, 0, 1);
        step(0, 16'h0, 0, 0, 0, 0, 1);
        step(1, 16'h0303, 0, 0, 0, 0, 0);
        check("R9 cap kept", cap_val, 16'h0202);
        check("R9 hold kept", hold_val, 16'h0101);
        check("R9 no flag", {15'd0, flag}, 16'h0);
        step(0, 16'h0, 0, 0, 1, 1, 0);
        step(1, 16'h0404, 0, 0, 0, 0, 0);
        check("R10 cap loaded after read", cap_val, 16'h0404);
        check("R10 hold untouched", hold_val, 16'h0101);

        // latch mode: R5, R6, R12
        set_mode(1, 1, 1, 0);
        step(1, 16'hE0E0, 0, 0, 0, 0, 0);
        check("R5 cap", cap_val, 16'hE0E0);
        check("R5 hold kept", hold_val, 16'h0101);
        check("R7 flag latch mode", {15'd0, flag}, 16'h1);
        step(0, 16'h0, 0, 1, 0, 0, 0);
        check("R6 force latch", hold_val, 16'hE0E0);
        step(1, 16'hF0F0, 1, 0, 0, 0, 0);
        check("R6 same cycle hold", hold_val, 16'hE0E0);
        check("R6 same cycle cap", cap_val, 16'hF0F0);
        step(0, 16'h0, 1, 0, 0, 0, 0);
        check("R6 latch event", hold_val, 16'hF0F0);

        // R11 set wins over clear
        set_mode(0, 0, 0, 0);
        step(1, 16'h5555, 0, 0, 0, 0, 1);
        check("R11 set wins", {15'd0, flag}, 16'h1);

        // random traffic against the reference
        for (int i = 0; i < 6000; i++) begin
            if (i % 60 == 0)
                set_mode($urandom_range(0, 3) != 0, $urandom_range(0, 1), $urandom_range(0, 1),
                         $urandom_range(0, 1));
            step($urandom_range(0, 2) == 0, CNT_W'($urandom),
                 $urandom_range(0, 7) == 0, $urandom_range(0, 15) == 0,
                 $urandom_range(0, 9) == 0, $urandom_range(0, 9) == 0,
                 $urandom_range(0, 5) == 0);
        end

        finished = 1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule